// File: doc/BRIEF.md
# Aperture Address Remapping Translator

This block sits on the path of bus-master requests and turns bus addresses that land inside a programmable remapping window into physical addresses. Each 4 KiB page of the window has a 32-bit entry in an internal table, and the entry holds a 40-bit page frame. The upper eight frame bits are packed into the low part of the entry. Addresses outside the window, and every address while translation is switched off, go through unchanged.

Software loads a control word and a base word through a configuration port and fills the table through a write port. Translation requests use a valid/ready port, and each answer carries the physical address, a fault flag and the entry's coherent flag. The most recently used entry is kept in a one-entry cache. A table write does not update that cache, so software must pulse `flush` after it changes an entry that may be cached. After reset every entry points at a scratch page, so a stray read through an unused slot still finds a valid mapping.

Top module: `apr_xlate`

## Requirements
- R1: After reset `resp_valid` is 0 and `req_ready` is 1. Every table entry holds `SCRATCH_ENT` (default 0x0007F003: valid, coherent, frame 0x7F000), so an enabled lookup of an unwritten index returns 0x7F000 plus the page offset with no fault.
- R2: A configuration write with `cfg_sel`=0 loads the control word, where bit 0 is the enable and bits 3:1 are the order. The window size is 32 MiB shifted left by the order. A write with `cfg_sel`=1 loads the base word, and the window base is bits 14:0 of that word shifted left by 25.
- R3: When the enable is clear, or the address lies below the base or at or above base plus size, the response address is the request address zero-extended to 40 bits, with fault 0 and coherent 0.
- R4: A window whose base plus size is greater than 4 GiB is treated as absent, and every address passes through as in R3. A window that ends exactly at 4 GiB is present.
- R5: Inside the window the index is (address − base) >> 12. With entry E valid, the response is {E[11:4], E[31:12], address[11:0]}.
- R6: An entry whose bit 0 (valid) is clear gives fault 1 and response address 0.
- R7: An index at or beyond `TBL_DEPTH` gives fault 1 and response address 0.
- R8: After a table write to the index that was last looked up from the table, lookups of that index keep returning the old entry until a `flush` pulse, or until a lookup of another index replaces the cached entry.
- R9: A request accepted in the same cycle as `flush` reads the table, not the cached entry.
- R10: The response appears in the cycle after the request is accepted. While `resp_ready` is low it holds stable, and `req_ready` stays low.
- R11: `resp_coh` reports entry bit 1 (coherent) for a translated address. It is 0 for pass-through and for faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = control word, 1 = base word |
| cfg_wdata | input | 32 | Configuration write data |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | IDX_W | Table write index |
| tbl_wdata | input | 32 | Table entry to store |
| flush | input | 1 | Invalidate the cached entry |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request can be accepted |
| req_addr | input | 32 | Bus address to translate |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Consumer takes the response |
| resp_addr | output | 40 | Physical address (0 on fault) |
| resp_fault | output | 1 | Invalid entry or index out of range |
| resp_coh | output | 1 | Coherent flag of the entry used |

## Verification
The two functions that can meet in one cycle are the cache invalidation and a lookup. The bench caches index 5, then rewrites that table entry, so the cache is deliberately stale. It then issues the next lookup of index 5 in the same cycle as the `flush` pulse and checks that the response carries the new frame, not the stale one. A separate sequence rewrites index 0 without a flush and expects the old frame back, which proves that the cache really is consulted and that the same-cycle result is not a trivial outcome.

// File: rtl/apr_pkg.sv
package apr_pkg;

    localparam int PAGE_SH = 12;
    localparam int BA_W    = 32;
    localparam int PA_W    = 40;
    localparam int ENT_W   = 32;
    localparam int FRM_W   = PA_W - PAGE_SH;

    typedef enum logic {
        CFG_CTL  = 1'b0,
        CFG_BASE = 1'b1
    } cfg_sel_e;

    typedef struct packed {
        logic       en;
        logic [2:0] order;
    } ctl_t;

    typedef struct packed {
        logic             vld;
        logic             coh;
        logic [FRM_W-1:0] frame;
    } ent_dec_t;

    typedef struct packed {
        logic [PA_W-1:0] addr;
        logic            fault;
        logic            coh;
    } resp_t;

    // unpack a table entry: high physical bits live in entry[11:4]
    function automatic ent_dec_t ent_decode(input logic [ENT_W-1:0] e);
        ent_dec_t d;
        d.vld   = e[0];
        d.coh   = e[1];
        d.frame = {e[11:4], e[31:12]};
        return d;
    endfunction

    // window size in bytes, 32 MiB << order
    function automatic logic [33:0] win_size(input logic [2:0] order);
        return 34'h0_0200_0000 << order;
    endfunction

endpackage

// File: rtl/apr_decode.sv
module apr_decode
    import apr_pkg::*;
#(
    parameter int TBL_DEPTH = 64,
    parameter int IDX_W     = $clog2(TBL_DEPTH)
) (
    input  logic             en,
    input  logic [2:0]       order,
    input  logic [14:0]      base_word,
    input  logic [BA_W-1:0]  addr,
    output logic             in_win,
    output logic             idx_ok,
    output logic [IDX_W-1:0] idx
);
    localparam logic [40:0] LIMIT = 41'h001_0000_0000;

    logic [39:0] base;
    logic [40:0] win_end;
    logic [40:0] addr_x;
    logic        present;
    logic [31:0] off;
    logic [19:0] pg;

    always_comb begin
        base    = {base_word, 25'b0};
        win_end = {1'b0, base} + {7'b0, win_size(order)};
        present = en && (win_end <= LIMIT);
        addr_x  = {9'b0, addr};
        in_win  = present && (addr_x >= {1'b0, base}) && (addr_x < win_end);
        off     = addr - base[31:0];
        pg      = off[31:PAGE_SH];
        idx_ok  = pg < 20'(TBL_DEPTH);
        idx     = pg[IDX_W-1:0];
    end

    logic unused_off;
    assign unused_off = ^off[PAGE_SH-1:0];

endmodule

// File: rtl/apr_table.sv
module apr_table
    import apr_pkg::*;
#(
    parameter int               TBL_DEPTH   = 64,
    parameter int               IDX_W       = $clog2(TBL_DEPTH),
    parameter logic [ENT_W-1:0] SCRATCH_ENT = 32'h0007_F003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [ENT_W-1:0] wdata,
    input  logic [IDX_W-1:0] ridx,
    output logic [ENT_W-1:0] rdata
);
    logic [ENT_W-1:0] mem [TBL_DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < TBL_DEPTH; i++) mem[i] <= SCRATCH_ENT;
        end else if (we && (32'(widx) < TBL_DEPTH)) begin
            mem[widx] <= wdata;
        end
    end

    always_comb begin
        rdata = SCRATCH_ENT;
        if (32'(ridx) < TBL_DEPTH) rdata = mem[ridx];
    end

endmodule

// File: rtl/apr_cache.sv
module apr_cache
    import apr_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             fill,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [ENT_W-1:0] fill_ent,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             hit,
    output logic [ENT_W-1:0] ent
);
    logic             vld_q;
    logic [IDX_W-1:0] idx_q;
    logic [ENT_W-1:0] ent_q;

    // a flush in this cycle hides the held entry from the lookup
    assign hit = vld_q && !flush && (idx_q == lk_idx);
    assign ent = ent_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            idx_q <= '0;
            ent_q <= '0;
        end else if (fill) begin
            vld_q <= 1'b1;
            idx_q <= fill_idx;
            ent_q <= fill_ent;
        end else if (flush) begin
            vld_q <= 1'b0;
        end
    end

endmodule

// File: rtl/apr_xlate.sv
module apr_xlate
    import apr_pkg::*;
#(
    parameter int          TBL_DEPTH   = 64,
    parameter int          IDX_W       = $clog2(TBL_DEPTH),
    parameter logic [31:0] SCRATCH_ENT = 32'h0007_F003
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [31:0]      cfg_wdata,
    input  logic             tbl_we,
    input  logic [IDX_W-1:0] tbl_idx,
    input  logic [31:0]      tbl_wdata,
    input  logic             flush,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    output logic             resp_valid,
    input  logic             resp_ready,
    output logic [39:0]      resp_addr,
    output logic             resp_fault,
    output logic             resp_coh
);
    ctl_t        ctl_q;
    logic [14:0] base_q;
    logic        xlate_on;
    resp_t       resp_q, resp_d;
    logic        vld_q;

    logic             in_win, idx_ok;
    logic [IDX_W-1:0] idx;
    logic [ENT_W-1:0] t_ent, c_ent, ent_sel;
    logic             c_hit, accept, fill;
    ent_dec_t         dec;

    assign xlate_on = ctl_q.en;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '0;
            base_q <= '0;
        end else if (cfg_we) begin
            if (cfg_sel_e'(cfg_sel) == CFG_CTL) begin
                ctl_q.en    <= cfg_wdata[0];
                ctl_q.order <= cfg_wdata[3:1];
            end else begin
                base_q <= cfg_wdata[14:0];
            end
        end
    end

    apr_decode #(.TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W)) u_dec (
        .en       (xlate_on),
        .order    (ctl_q.order),
        .base_word(base_q),
        .addr     (req_addr),
        .in_win   (in_win),
        .idx_ok   (idx_ok),
        .idx      (idx)
    );

    apr_table #(.TBL_DEPTH(TBL_DEPTH), .IDX_W(IDX_W), .SCRATCH_ENT(SCRATCH_ENT)) u_tbl (
        .clk  (clk),
        .rst  (rst),
        .we   (tbl_we),
        .widx (tbl_idx),
        .wdata(tbl_wdata),
        .ridx (idx),
        .rdata(t_ent)
    );

    assign req_ready = !vld_q || resp_ready;
    assign accept    = req_valid && req_ready;
    assign fill      = accept && in_win && idx_ok && !c_hit;

    apr_cache #(.IDX_W(IDX_W)) u_cache (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .fill    (fill),
        .fill_idx(idx),
        .fill_ent(t_ent),
        .lk_idx  (idx),
        .hit     (c_hit),
        .ent     (c_ent)
    );

    always_comb begin
        ent_sel = c_hit ? c_ent : t_ent;
        dec     = ent_decode(ent_sel);
        if (!in_win) begin
            resp_d = '{addr: {8'b0, req_addr}, fault: 1'b0, coh: 1'b0};
        end else if (!idx_ok || !dec.vld) begin
            resp_d = '{addr: '0, fault: 1'b1, coh: 1'b0};
        end else begin
            resp_d = '{addr: {dec.frame, req_addr[PAGE_SH-1:0]}, fault: 1'b0, coh: dec.coh};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            resp_q <= '0;
        end else if (accept) begin
            vld_q  <= 1'b1;
            resp_q <= resp_d;
        end else if (resp_ready) begin
            vld_q  <= 1'b0;
        end
    end

    assign resp_valid = vld_q;
    assign resp_addr  = resp_q.addr;
    assign resp_fault = resp_q.fault;
    assign resp_coh   = resp_q.coh;

    logic unused_bits;
    assign unused_bits = ^{cfg_wdata[31:15], ent_sel[3:2]};

endmodule

// File: rtl/apr_xlate_chk.sv
module apr_xlate_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_addr,
    input logic        resp_valid,
    input logic        resp_ready,
    input logic [39:0] resp_addr,
    input logic        resp_fault,
    input logic        resp_coh,
    input logic        ctl_en
);
    // R10
    resp_follows_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> resp_valid);

    // R10
    resp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_addr)
                                         && $stable(resp_fault) && $stable(resp_coh)));

    // R6
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_fault) |-> (resp_addr == 40'h0 && !resp_coh));

    // R3
    off_passthru_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && !ctl_en) |=>
            (resp_addr == {8'h0, $past(req_addr)} && !resp_fault && !resp_coh));

    // R5
    page_offset_kept_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=>
            (resp_fault || resp_addr[11:0] == $past(req_addr[11:0])));

endmodule

bind apr_xlate apr_xlate_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_addr  (req_addr),
    .resp_valid(resp_valid),
    .resp_ready(resp_ready),
    .resp_addr (resp_addr),
    .resp_fault(resp_fault),
    .resp_coh  (resp_coh),
    .ctl_en    (xlate_on)
);

// File: tb/apr_xlate_tb.sv
module apr_xlate_tb;

    localparam int DEPTH = 64;
    localparam int IW    = 6;
    localparam int NV    = 9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0]   cfg_wdata = '0;
    logic          tbl_we = 1'b0;
    logic [IW-1:0] tbl_idx = '0;
    logic [31:0]   tbl_wdata = '0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = '0;
    logic          resp_valid;
    logic          resp_ready = 1'b1;
    logic [39:0]   resp_addr;
    logic          resp_fault, resp_coh;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    apr_xlate #(.TBL_DEPTH(DEPTH)) u_dut (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .tbl_we(tbl_we), .tbl_idx(tbl_idx), .tbl_wdata(tbl_wdata),
        .flush(flush),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_addr(resp_addr),
        .resp_fault(resp_fault), .resp_coh(resp_coh)
    );

    // window at 0x0400_0000, 32 MiB; table has idx0, idx1 (invalid), idx5, idx63 loaded
    localparam logic [31:0] V_ADDR [NV] = '{
        32'h0400_0678, 32'h0400_1FFF, 32'h0400_5ABC, 32'h0403_F010, 32'h0404_0000,
        32'h0400_2345, 32'h03FF_FFFF, 32'h0600_0000, 32'h05FF_FFFF};
    localparam logic [39:0] V_EXP [NV] = '{
        40'hAB_1234_5678, 40'h0, 40'h01_FFFF_FABC, 40'h00_00AB_C010, 40'h0,
        40'h00_0007_F345, 40'h00_03FF_FFFF, 40'h00_0600_0000, 40'h0};
    localparam logic [NV-1:0] V_FLT = 9'b100010010;
    localparam logic [NV-1:0] V_COH = 9'b000100001;
    localparam string V_REQ [NV] = '{"R5", "R6", "R5", "R5", "R7", "R1", "R3", "R3", "R7"};

    task automatic check(input string req, input logic [39:0] ga, input logic [39:0] ea,
                         input logic gf, input logic ef, input logic gc, input logic ec);
        n_chk++;
        if (ga !== ea || gf !== ef || gc !== ec) begin
            n_bad++;
            $display("FAIL %s: addr=%h fault=%b coh=%b expected addr=%h fault=%b coh=%b",
                     req, ga, gf, gc, ea, ef, ec);
        end
    endtask

    task automatic cfg(input logic sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic twr(input int i, input logic [31:0] d);
        @(negedge clk);
        tbl_we = 1'b1; tbl_idx = IW'(i); tbl_wdata = d;
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    // drive at negedge, accepted at the next posedge, response sampled at the following negedge
    task automatic lookup(input logic [31:0] a, input logic fl);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; flush = fl;
        @(negedge clk);
        req_valid = 1'b0; flush = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state of handshake
        check("R1", {38'b0, resp_valid, req_ready}, 40'h1, 1'b0, 1'b0, 1'b0, 1'b0);

        cfg(1'b1, 32'h0000_0002);
        twr(0, 32'h1234_5AB3);
        twr(1, 32'h0001_0000);
        twr(5, 32'hFFFF_F011);
        twr(63, 32'h00AB_C001);

        // R3: enable still clear, address inside the would-be window passes
        lookup(32'h0400_0678, 1'b0);
        check("R3", resp_addr, 40'h00_0400_0678, resp_fault, 1'b0, resp_coh, 1'b0);

        // R2: enable bit 0, order 0
        cfg(1'b0, 32'h0000_0001);
        for (int v = 0; v < NV; v++) begin
            lookup(V_ADDR[v], 1'b0);
            check(V_REQ[v], resp_addr, V_EXP[v], resp_fault, V_FLT[v], resp_coh, V_COH[v]);
        end

        // R2: order 2 makes the window 128 MiB, so 0x0700_0000 is inside (index too big)
        cfg(1'b0, 32'h0000_0005);
        lookup(32'h0700_0000, 1'b0);
        check("R2", resp_addr, 40'h0, resp_fault, 1'b1, resp_coh, 1'b0);

        // R4: base 0xFE00_0000 with 64 MiB crosses 4 GiB -> absent
        cfg(1'b1, 32'h0000_007F);
        cfg(1'b0, 32'h0000_0003);
        lookup(32'hFE00_0123, 1'b0);
        check("R4", resp_addr, 40'h00_FE00_0123, resp_fault, 1'b0, resp_coh, 1'b0);
        // R4: 32 MiB ends exactly at 4 GiB -> present
        cfg(1'b0, 32'h0000_0001);
        lookup(32'hFE00_0123, 1'b0);
        check("R4", resp_addr, 40'hAB_1234_5123, resp_fault, 1'b0, resp_coh, 1'b1);

        // R8: stale cache until flush
        cfg(1'b1, 32'h0000_0002);
        lookup(32'h0400_0010, 1'b0);
        twr(0, 32'h1111_1003);
        lookup(32'h0400_0020, 1'b0);
        check("R8", resp_addr, 40'hAB_1234_5020, resp_fault, 1'b0, resp_coh, 1'b1);
        @(negedge clk); flush = 1'b1;
        @(negedge clk); flush = 1'b0;
        lookup(32'h0400_0030, 1'b0);
        check("R8", resp_addr, 40'h00_1111_1030, resp_fault, 1'b0, resp_coh, 1'b1);

        // R9: flush in the same cycle as the lookup
        lookup(32'h0400_5000, 1'b0);
        twr(5, 32'h2222_2003);
        lookup(32'h0400_5044, 1'b1);
        check("R9", resp_addr, 40'h00_2222_2044, resp_fault, 1'b0, resp_coh, 1'b1);

        // R10: stall holds response and blocks requests
        @(negedge clk); resp_ready = 1'b0;
        lookup(32'h0400_0100, 1'b0);
        check("R10", resp_addr, 40'h00_1111_1100, resp_fault, 1'b0, resp_coh, 1'b1);
        repeat (2) @(negedge clk);
        check("R10", {38'b0, resp_valid, req_ready}, 40'h2, 1'b0, 1'b0, 1'b0, 1'b0);
        check("R10", resp_addr, 40'h00_1111_1100, resp_fault, 1'b0, resp_coh, 1'b1);
        resp_ready = 1'b1;
        @(negedge clk);
        check("R10", {39'b0, resp_valid}, 40'h0, 1'b0, 1'b0, 1'b0, 1'b0);

        // R3: enable cleared again
        cfg(1'b0, 32'h0000_0000);
        lookup(32'h0400_0678, 1'b0);
        check("R3", resp_addr, 40'h00_0400_0678, resp_fault, 1'b0, resp_coh, 1'b0);

        // R11: coherent flag clear on a translated entry
        cfg(1'b0, 32'h0000_0001);
        lookup(32'h0400_5001, 1'b1);
        check("R11", resp_addr, 40'h00_2222_2001, resp_fault, 1'b0, resp_coh, 1'b1);
        twr(5, 32'h3333_3001);
        lookup(32'h0400_5002, 1'b1);
        check("R11", resp_addr, 40'h00_3333_3002, resp_fault, 1'b0, resp_coh, 1'b0);

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule